// File: doc/BRIEF.md
# Low-Power Sleep and Wake Controller

This controller tells a processor core when to stop and when to start again. The core can ask to wait for an interrupt or to wait for an event. Sleep can also be entered automatically when a handler finishes and control returns to thread mode, if a configuration bit allows it. While the core is stopped, the controller watches the interrupt pending and enable vectors, the send-event pulse and the external event input. When a valid wake source appears, it gives a single wake pulse and then releases the sleep flags.

A one-bit event latch records events that arrive when the core is not stopped in a wait-for-event. Because of this latch, an event cannot be lost between the time software decides to wait and the time it actually issues the request. The next wait-for-event finds the latch set, clears it and does not sleep at all. A configuration bit lets newly pending interrupts count as events even when they are masked. A second bit selects deep sleep rather than normal sleep, and its value is sampled when sleep is entered.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `sleeping`, `deep_sleep` and `wake` are 0, and the event latch is clear. As a result, a first `wfe_req` with no event present enters sleep.
- R2: In the running state, a `wfi_req` sampled at a clock edge sets `sleeping` to 1 from that edge on, with `wake` at 0.
- R3: When `cfg_sleep_on_exit` is 1, an `exc_return_thread` sampled in the running state enters sleep with the same wake rule as R5. When `cfg_sleep_on_exit` is 0, the block keeps running.
- R4: `cfg_deep_sel` is sampled at the edge that enters sleep, with 1 meaning deep and 0 meaning normal. `deep_sleep` equals that sampled value for as long as `sleeping` is 1, even if `cfg_deep_sel` changes later. `deep_sleep` is 0 whenever `sleeping` is 0.
- R5: A sleep entered by `wfi_req` or by sleep-on-exit ends only when some bit i has both `irq_pend[i]` and `irq_en[i]` at 1. `sev_pulse`, `ext_event`, masked pending bits and the event latch have no effect on it.
- R6: Three things are events: `sev_pulse`, `ext_event`, and a 0-to-1 change of any `irq_pend[i]`. When `cfg_sev_on_pend` is 0, a pending change counts only if `irq_en[i]` is 1; when it is 1, any bit counts. An event ends a sleep entered by `wfe_req`.
- R7: An event that occurs while the block is not asleep in a wait-for-event sets the latch. A later `wfe_req` with the latch set keeps the block running, gives no `wake` pulse and clears the latch. The following `wfe_req` with no event then sleeps.
- R8: A `wfe_req` that coincides with an event keeps the block running, exactly as if the latch had been set.
- R9: The first edge that sees the wake condition raises `wake` for exactly one cycle. During that cycle `sleeping` (and `deep_sleep`, if it was set) stays 1. Both drop at the next edge.
- R10: If `wfi_req` (or a sleep-on-exit return) and `wfe_req` arrive together, the interrupt wait is taken. Requests that arrive while asleep or during the wake cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| wfe_req | input | 1 | Wait-for-event request from the core |
| sev_pulse | input | 1 | Send-event pulse |
| ext_event | input | 1 | External event input |
| irq_pend | input | N_IRQ | Per-interrupt pending vector |
| irq_en | input | N_IRQ | Per-interrupt enable vector |
| exc_return_thread | input | 1 | Return from handler mode to thread mode |
| cfg_sleep_on_exit | input | 1 | Sleep when returning to thread mode |
| cfg_deep_sel | input | 1 | 0 selects normal sleep, 1 selects deep sleep |
| cfg_sev_on_pend | input | 1 | Any newly pending interrupt counts as an event |
| sleeping | output | 1 | Core is in a low-power state |
| deep_sleep | output | 1 | The low-power state is deep sleep |
| wake | output | 1 | One-cycle wake pulse |

## Verification
Some properties are checked by assertions on every cycle. Wake is a single pulse, and it only occurs while asleep. Both flags drop right after the pulse. The deep-sleep flag holds steady through a sleep. Consuming the latch never leads to sleep. An interrupt wait with no enabled pending interrupt never wakes. Other behaviour needs the bench's scenarios, driven against a cycle-level reference model. That includes the event latch carrying an event across a stretch of time and then being used once. It also includes masked interrupts waking only when send-event-on-pend is set, the interrupt wait ignoring events, and the priority of the interrupt wait over a simultaneous wait-for-event.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAIT_IRQ = 2'd1,
    ST_WAIT_EVT = 2'd2,
    ST_WAKE     = 2'd3
  } swc_state_e;

  function automatic logic state_asleep(input swc_state_e s);
    return s != ST_RUN;
  endfunction
endpackage

// File: rtl/swc_event_detect.sv
module swc_event_detect #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             sev_on_pend,
  input  logic             sev_pulse,
  input  logic             ext_event,
  output logic             evt_src,
  output logic             irq_wake
);
  logic [N_IRQ-1:0] pend_q;
  logic             pend_hit;

  function automatic logic edge_hit(input logic [N_IRQ-1:0] now,
                                    input logic [N_IRQ-1:0] prev,
                                    input logic [N_IRQ-1:0] en,
                                    input logic             all);
    logic [N_IRQ-1:0] mask;
    mask = all ? {N_IRQ{1'b1}} : en;
    return |(now & ~prev & mask);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_pend;
  end

  assign pend_hit = edge_hit(irq_pend, pend_q, irq_en, sev_on_pend);
  assign evt_src  = sev_pulse | ext_event | pend_hit;
  assign irq_wake = |(irq_pend & irq_en);

  AST_MASKED_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sev_on_pend && !sev_pulse && !ext_event && (irq_en == '0)) |-> !evt_src); // R6
endmodule

// File: rtl/swc_event_latch.sv
module swc_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_src,
  input  logic set_ok,
  input  logic consume,
  output logic latched
);
  always_ff @(posedge clk) begin
    if (!rst_n)                latched <= 1'b0;
    else if (consume)          latched <= 1'b0;
    else if (evt_src && set_ok) latched <= 1'b1;
  end

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !latched); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !consume) |=> latched); // R7
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic exc_return_thread,
  input  logic cfg_sleep_on_exit,
  input  logic cfg_deep_sel,
  input  logic evt_src,
  input  logic irq_wake,
  input  logic latched,
  output logic consume,
  output logic set_ok,
  output logic sleeping,
  output logic deep_sleep,
  output logic wake
);
  swc_state_e state_q, state_d;
  logic       deep_q;
  logic       go_irq, wfe_try, go_evt, wake_cond, enter;

  assign go_irq    = (state_q == ST_RUN) & (wfi_req | (exc_return_thread & cfg_sleep_on_exit));
  assign wfe_try   = (state_q == ST_RUN) & ~go_irq & wfe_req;
  assign consume   = wfe_try & (latched | evt_src);
  assign go_evt    = wfe_try & ~consume;
  assign enter     = go_irq | go_evt;
  assign wake_cond = ((state_q == ST_WAIT_IRQ) & irq_wake) |
                     ((state_q == ST_WAIT_EVT) & evt_src);
  assign set_ok    = state_q != ST_WAIT_EVT;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (go_irq) state_d = ST_WAIT_IRQ;
                   else if (go_evt) state_d = ST_WAIT_EVT;
      ST_WAIT_IRQ,
      ST_WAIT_EVT: if (wake_cond) state_d = ST_WAKE;
      ST_WAKE:     state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter)                  deep_q <= cfg_deep_sel;
      else if (state_q == ST_WAKE) deep_q <= 1'b0;
    end
  end

  assign sleeping   = state_asleep(state_q);
  assign deep_sleep = deep_q & sleeping;
  assign wake       = state_q == ST_WAKE;

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R9
  AST_FLAGS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!sleeping && !deep_sleep)); // R9
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleeping); // R9
  AST_DEEP_IMPLIES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> sleeping); // R4
  AST_DEEP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |=> (!sleeping || $stable(deep_sleep))); // R4
  AST_CONSUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (!sleeping && !wake)); // R7
  AST_WFI_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    go_irq |=> (sleeping && !wake)); // R2
  AST_WFI_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT_IRQ) && !irq_wake) |=> !wake); // R5
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             wfe_req,
  input  logic             sev_pulse,
  input  logic             ext_event,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             exc_return_thread,
  input  logic             cfg_sleep_on_exit,
  input  logic             cfg_deep_sel,
  input  logic             cfg_sev_on_pend,
  output logic             sleeping,
  output logic             deep_sleep,
  output logic             wake
);
  logic evt_src, irq_wake, latched, consume, set_ok;

  swc_event_detect #(.N_IRQ(N_IRQ)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pend   (irq_pend),
    .irq_en     (irq_en),
    .sev_on_pend(cfg_sev_on_pend),
    .sev_pulse  (sev_pulse),
    .ext_event  (ext_event),
    .evt_src    (evt_src),
    .irq_wake   (irq_wake)
  );

  swc_event_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_src(evt_src),
    .set_ok (set_ok),
    .consume(consume),
    .latched(latched)
  );

  swc_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .wfi_req          (wfi_req),
    .wfe_req          (wfe_req),
    .exc_return_thread(exc_return_thread),
    .cfg_sleep_on_exit(cfg_sleep_on_exit),
    .cfg_deep_sel     (cfg_deep_sel),
    .evt_src          (evt_src),
    .irq_wake         (irq_wake),
    .latched          (latched),
    .consume          (consume),
    .set_ok           (set_ok),
    .sleeping         (sleeping),
    .deep_sleep       (deep_sleep),
    .wake             (wake)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sleeping && !wake)); // R1
endmodule

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, sev_pulse = 0, ext_event = 0, exc_ret = 0;
  logic soe = 0, deep_sel = 0, sop = 0;
  logic [N-1:0] pend = '0, en = '0;
  logic sleeping, deep_sleep, wake;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_pulse(sev_pulse), .ext_event(ext_event), .irq_pend(pend), .irq_en(en),
    .exc_return_thread(exc_ret), .cfg_sleep_on_exit(soe), .cfg_deep_sel(deep_sel),
    .cfg_sev_on_pend(sop), .sleeping(sleeping), .deep_sleep(deep_sleep), .wake(wake)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // reference model: 0 running, 1 irq wait, 2 event wait, 3 waking
  int m_state = 0;
  bit m_latch = 0, m_deep = 0;
  bit [N-1:0] m_prev = '0;

  always @(posedge clk) begin
    bit evt, irqw, used;
    int old;
    if (!rst_n) begin
      m_state = 0; m_latch = 0; m_deep = 0; m_prev = '0;
    end else begin
      evt = sev_pulse || ext_event;
      irqw = 0;
      for (int i = 0; i < N; i++) begin
        if (pend[i] && !m_prev[i] && (sop || en[i])) evt = 1;
        if (pend[i] && en[i]) irqw = 1;
      end
      used = 0;
      old = m_state;
      if (old == 0) begin
        if (wfi_req || (exc_ret && soe)) begin m_state = 1; m_deep = deep_sel; end
        else if (wfe_req) begin
          if (m_latch || evt) used = 1;
          else begin m_state = 2; m_deep = deep_sel; end
        end
      end else if (old == 1) begin
        if (irqw) m_state = 3;
      end else if (old == 2) begin
        if (evt) m_state = 3;
      end else begin
        m_state = 0; m_deep = 0;
      end
      if (used) m_latch = 0;
      else if (evt && old != 2) m_latch = 1;
      m_prev = pend;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit es, ed, ew;
      es = (m_state != 0);
      ed = es && m_deep;
      ew = (m_state == 3);
      checks++;
      if (sleeping !== es || deep_sleep !== ed || wake !== ew) begin
        fails++;
        $display("FAIL %s model: sleep/deep/wake = %b%b%b expected %b%b%b",
                 tag, sleeping, deep_sleep, wake, es, ed, ew);
      end
    end
  end

  task automatic expect_bit(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s = %b expected %b", t, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired in %s", tag);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    step(3);
    expect_bit("R1", "sleeping", sleeping, 1'b0);
    expect_bit("R1", "wake", wake, 1'b0);
    rst_n = 1; step(2);
    expect_bit("R1", "deep_sleep", deep_sleep, 1'b0);
    wfe_req = 1; step(1); wfe_req = 0;
    expect_bit("R1", "sleeping after first wfe", sleeping, 1'b1);
    ext_event = 1; step(1); ext_event = 0;
    step(2);

    // R2 / R5: interrupt wait
    tag = "R2";
    wfi_req = 1; step(1); wfi_req = 0;
    expect_bit("R2", "sleeping", sleeping, 1'b1);
    expect_bit("R2", "wake", wake, 1'b0);
    tag = "R5";
    sev_pulse = 1; step(1); sev_pulse = 0;   // also sets the latch
    ext_event = 1; step(1); ext_event = 0;
    pend[2] = 1; step(3);
    expect_bit("R5", "sleeping with masked pend and events", sleeping, 1'b1);
    tag = "R9";
    en[2] = 1; step(1);
    expect_bit("R9", "wake pulse", wake, 1'b1);
    expect_bit("R9", "sleeping during pulse", sleeping, 1'b1);
    step(1);
    expect_bit("R9", "wake after pulse", wake, 1'b0);
    expect_bit("R9", "sleeping after pulse", sleeping, 1'b0);
    pend = '0; en = '0; step(2);

    // R7: latched event consumed by wfe
    tag = "R7";
    wfe_req = 1; step(1); wfe_req = 0;
    expect_bit("R7", "sleeping with latch set", sleeping, 1'b0);
    expect_bit("R7", "no wake on consume", wake, 1'b0);
    step(2);
    wfe_req = 1; step(1); wfe_req = 0;
    expect_bit("R7", "sleeping after latch used", sleeping, 1'b1);
    tag = "R6";
    ext_event = 1; step(1); ext_event = 0;
    expect_bit("R6", "wake on ext event", wake, 1'b1);
    step(3);

    // R3 / R4: sleep on exit and deep select
    tag = "R3";
    soe = 0; exc_ret = 1; step(1); exc_ret = 0;
    expect_bit("R3", "running without sleep-on-exit", sleeping, 1'b0);
    soe = 1; deep_sel = 1; exc_ret = 1; step(1); exc_ret = 0;
    expect_bit("R3", "sleeping on exit", sleeping, 1'b1);
    tag = "R4";
    expect_bit("R4", "deep sleep", deep_sleep, 1'b1);
    deep_sel = 0; step(3);
    expect_bit("R4", "deep held", deep_sleep, 1'b1);
    tag = "R3";
    sev_pulse = 1; step(1); sev_pulse = 0; step(2);
    expect_bit("R3", "exit sleep ignores event", sleeping, 1'b1);
    pend[0] = 1; en[0] = 1; step(1);
    expect_bit("R4", "deep during wake pulse", deep_sleep, 1'b1);
    step(1);
    expect_bit("R4", "deep dropped", deep_sleep, 1'b0);
    pend = '0; en = '0; soe = 0; step(2);
    wfe_req = 1; step(1); wfe_req = 0;          // consume latched events
    expect_bit("R7", "consume leftover latch", sleeping, 1'b0);
    step(2);

    // R6: send-event-on-pend
    tag = "R6";
    sop = 0; wfe_req = 1; step(1); wfe_req = 0;
    expect_bit("R6", "wfe sleeping", sleeping, 1'b1);
    pend[5] = 1; step(3);
    expect_bit("R6", "masked pend ignored", sleeping, 1'b1);
    sop = 1; pend[6] = 1; step(1);
    expect_bit("R6", "masked pend wakes with sop", wake, 1'b1);
    pend = '0; sop = 0; step(3);
    wfe_req = 1; step(1); wfe_req = 0;
    en[1] = 1; pend[1] = 1; step(1);
    expect_bit("R6", "enabled pend edge wakes", wake, 1'b1);
    pend = '0; en = '0; step(3);

    // R8: coincident event
    tag = "R8";
    wfe_req = 1; sev_pulse = 1; step(1); wfe_req = 0; sev_pulse = 0;
    expect_bit("R8", "running with coincident event", sleeping, 1'b0);
    step(2);

    // R10: priority and ignored requests
    tag = "R10";
    wfi_req = 1; wfe_req = 1; deep_sel = 1; step(1); wfi_req = 0; wfe_req = 0;
    deep_sel = 0;
    ext_event = 1; step(1); ext_event = 0; step(2);
    expect_bit("R10", "interrupt wait taken", sleeping, 1'b1);
    wfe_req = 1; step(1); wfe_req = 0;
    sev_pulse = 1; step(1); sev_pulse = 0; step(2);
    expect_bit("R10", "request while asleep ignored", sleeping, 1'b1);
    pend[7] = 1; en[7] = 1; step(1);
    wfi_req = 1; step(1); wfi_req = 0;
    expect_bit("R10", "request during wake ignored", sleeping, 1'b0);
    pend = '0; en = '0; step(3);

    // mixed stimulus compared against the model
    tag = "R9";
    for (int c = 0; c < 3000; c++) begin
      wfi_req   = ($urandom_range(0, 15) == 0);
      wfe_req   = ($urandom_range(0, 7) == 0);
      sev_pulse = ($urandom_range(0, 15) == 0);
      ext_event = ($urandom_range(0, 15) == 0);
      exc_ret   = ($urandom_range(0, 15) == 0);
      soe       = $urandom_range(0, 1);
      deep_sel  = $urandom_range(0, 1);
      sop       = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) pend = N'($urandom);
      if ($urandom_range(0, 9) == 0) en = N'($urandom);
      step(1);
    end
    finish_run();
  end
endmodule